// File: doc/BRIEF.md
# Short Conditional Branch Decoder

This block sits in an instruction front end. It looks at the first two bytes of a fetched instruction and decides whether they form a two-byte short conditional jump. It then tests that jump's condition against the current arithmetic flags and works out where fetch goes next. The first byte is an opcode whose upper nibble marks the jump form and whose lower nibble selects a condition. The second byte is a signed 8-bit displacement.

The condition nibble splits into a 3-bit test selector and an invert bit. The least significant bit flips the result of the test chosen by the upper three bits, so one small evaluator serves all eight condition pairs. Results are registered, so they appear one clock after the bytes are presented with a valid strobe.

The block produces four results: the fall-through address, which is the opcode address plus two; the target address, which is the fall-through plus the sign-extended displacement; a taken bit; and the selected next fetch address. All address arithmetic wraps at the address width.

Top module: `jcc_short_decoder`

## Requirements
- R1: When `in_valid` is high and `op_byte[7:4]` equals 4'b0111, then on the next clock `out_valid` and `is_jcc` are both 1.
- R2: When `in_valid` is high and `op_byte[7:4]` is not 4'b0111, then on the next clock `is_jcc` is 0 and `taken` is 0, whatever the flags are.
- R3: The test selector `op_byte[3:1]` chooses the base test as follows: 000 is OF=1, 001 is CF=1, 010 is ZF=1, 011 is CF=1 or ZF=1, 100 is SF=1, 101 is PF=1, 110 is SF!=OF, and 111 is ZF=1 or SF!=OF. For a recognised jump, `taken` equals the base test when `op_byte[0]`=0.
- R4: When `op_byte[0]`=1, `taken` is the inverse of the base test. For example, condition 4'b0100 jumps when ZF=1 and 4'b0101 jumps when ZF=0.
- R5: For every valid input, `fall_addr` equals `insn_addr` + 2 modulo 2^ADDR_W.
- R6: For every valid input, `target_addr` equals `insn_addr` + 2 + the sign-extended `disp_byte`, modulo 2^ADDR_W. This holds across wrap at both the top and the bottom of the address space.
- R7: A displacement of 8'hFB gives a `target_addr` five bytes below `fall_addr`.
- R8: `next_addr` equals `target_addr` when `taken` is 1, and otherwise equals `fall_addr`.
- R9: After synchronous reset, `out_valid`, `is_jcc` and `taken` are 0, and all three address outputs are 0.
- R10: A cycle with `in_valid` low gives, one clock later, `out_valid`=0, `is_jcc`=0 and `taken`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction bytes and address are valid this cycle |
| op_byte | input | 8 | First instruction byte (opcode) |
| disp_byte | input | 8 | Second instruction byte (signed displacement) |
| insn_addr | input | ADDR_W | Address of the opcode byte |
| flag_zf | input | 1 | Zero flag |
| flag_cf | input | 1 | Carry flag |
| flag_sf | input | 1 | Sign flag |
| flag_of | input | 1 | Overflow flag |
| flag_pf | input | 1 | Parity flag |
| out_valid | output | 1 | Registered results are valid |
| is_jcc | output | 1 | The bytes form a short conditional jump |
| taken | output | 1 | The jump condition holds |
| fall_addr | output | ADDR_W | Address of the next sequential instruction |
| target_addr | output | ADDR_W | Branch target address |
| next_addr | output | ADDR_W | Selected next fetch address |

## Verification
Some properties are checked by assertions on every cycle:
- a taken result never appears without a recognised jump;
- non-jump opcodes and invalid cycles never yield `is_jcc` or `taken`;
- the fall-through address always tracks the registered opcode address plus two;
- the next fetch address always agrees with the taken bit.

Other behaviour can only be shown by the bench's scenarios: the per-condition flag tests, the inversion by the low condition bit, sign extension of negative displacements, and wrap at both ends of the address space. The bench covers these with directed cases for every condition nibble and with seeded random bytes and flags.

// File: rtl/jcc_pkg.sv
package jcc_pkg;

    localparam int unsigned OPC_W   = 8;
    localparam int unsigned DISP_W  = 8;
    localparam int unsigned INSN_LEN = 2;
    localparam logic [3:0]  JCC_MARK = 4'b0111;

    typedef enum logic [2:0] {
        TST_OVF   = 3'd0,
        TST_CARRY = 3'd1,
        TST_ZERO  = 3'd2,
        TST_BELEQ = 3'd3,
        TST_SIGN  = 3'd4,
        TST_PAR   = 3'd5,
        TST_LESS  = 3'd6,
        TST_LEQ   = 3'd7
    } tst_sel_e;

    typedef struct packed {
        logic zf;
        logic cf;
        logic sf;
        logic of;
        logic pf;
    } flags_t;

    typedef struct packed {
        tst_sel_e sel;
        logic     inv;
    } cond_t;

    function automatic logic base_test(input tst_sel_e sel, input flags_t f);
        logic r;
        case (sel)
            TST_OVF:   r = f.of;
            TST_CARRY: r = f.cf;
            TST_ZERO:  r = f.zf;
            TST_BELEQ: r = f.cf | f.zf;
            TST_SIGN:  r = f.sf;
            TST_PAR:   r = f.pf;
            TST_LESS:  r = f.sf ^ f.of;
            default:   r = (f.sf ^ f.of) | f.zf;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/jcc_opcode_match.sv
module jcc_opcode_match
    import jcc_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output logic             hit,
    output cond_t            cond
);
    always_comb begin
        hit      = (opcode[OPC_W-1:4] == JCC_MARK);
        cond.sel = tst_sel_e'(opcode[3:1]);
        cond.inv = opcode[0];
    end
endmodule

// File: rtl/jcc_cond_eval.sv
module jcc_cond_eval
    import jcc_pkg::*;
(
    input  cond_t  cond,
    input  flags_t flags,
    output logic   pass
);
    logic base;

    always_comb begin
        base = base_test(cond.sel, flags);
        pass = base ^ cond.inv;
    end
endmodule

// File: rtl/jcc_addr_calc.sv
module jcc_addr_calc
    import jcc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base_addr,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] seq_addr,
    output logic [ADDR_W-1:0] br_addr
);
    localparam int unsigned EXT_W = ADDR_W - DISP_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSN_LEN);

    logic [ADDR_W-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};
        seq_addr = base_addr + STEP;
        br_addr  = seq_addr + disp_ext;
    end
endmodule

// File: rtl/jcc_short_decoder.sv
module jcc_short_decoder
    import jcc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [7:0]        op_byte,
    input  logic [7:0]        disp_byte,
    input  logic [ADDR_W-1:0] insn_addr,
    input  logic              flag_zf,
    input  logic              flag_cf,
    input  logic              flag_sf,
    input  logic              flag_of,
    input  logic              flag_pf,
    output logic              out_valid,
    output logic              is_jcc,
    output logic              taken,
    output logic [ADDR_W-1:0] fall_addr,
    output logic [ADDR_W-1:0] target_addr,
    output logic [ADDR_W-1:0] next_addr
);
    flags_t            flg;
    cond_t             cond;
    logic              hit;
    logic              pass;
    logic [ADDR_W-1:0] seq_c;
    logic [ADDR_W-1:0] br_c;

    assign flg = '{zf: flag_zf, cf: flag_cf, sf: flag_sf, of: flag_of, pf: flag_pf};

    jcc_opcode_match u_match (
        .opcode (op_byte),
        .hit    (hit),
        .cond   (cond)
    );

    jcc_cond_eval u_eval (
        .cond  (cond),
        .flags (flg),
        .pass  (pass)
    );

    jcc_addr_calc #(.ADDR_W(ADDR_W)) u_addr (
        .base_addr (insn_addr),
        .disp      (disp_byte),
        .seq_addr  (seq_c),
        .br_addr   (br_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid   <= 1'b0;
            is_jcc      <= 1'b0;
            taken       <= 1'b0;
            fall_addr   <= '0;
            target_addr <= '0;
            next_addr   <= '0;
        end else begin
            out_valid <= in_valid;
            is_jcc    <= in_valid & hit;
            taken     <= in_valid & hit & pass;
            if (in_valid) begin
                fall_addr   <= seq_c;
                target_addr <= br_c;
                next_addr   <= (hit & pass) ? br_c : seq_c;
            end
        end
    end

    // R2: taken only ever accompanies a recognised jump
    p_taken_needs_jcc_r2: assert property (@(posedge clk) disable iff (rst)
        taken |-> is_jcc)
        else $error("taken without is_jcc");

    // R2: a non-jump opcode never yields is_jcc or taken
    p_nonjcc_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op_byte[7:4] != 4'b0111) |=> (!is_jcc && !taken))
        else $error("non-jump opcode flagged");

    // R10: invalid cycle produces no result
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && !is_jcc && !taken))
        else $error("idle cycle produced output");

    // R5: fall-through follows the presented address by two
    p_fall_step_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (fall_addr == $past(insn_addr) + ADDR_W'(2)))
        else $error("fall-through address wrong");

    // R8: next fetch agrees with the taken decision
    p_next_sel_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (next_addr == (taken ? target_addr : fall_addr)))
        else $error("next address disagrees with taken");

endmodule

// File: tb/sim_jcc_short_decoder.sv
module sim_jcc_short_decoder;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst;
    logic          in_valid;
    logic [7:0]    op_byte, disp_byte;
    logic [AW-1:0] insn_addr;
    logic          zf, cf, sf, ovf, pf;
    logic          out_valid, is_jcc, taken;
    logic [AW-1:0] fall_addr, target_addr, next_addr;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    jcc_short_decoder #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .op_byte(op_byte), .disp_byte(disp_byte), .insn_addr(insn_addr),
        .flag_zf(zf), .flag_cf(cf), .flag_sf(sf), .flag_of(ovf), .flag_pf(pf),
        .out_valid(out_valid), .is_jcc(is_jcc), .taken(taken),
        .fall_addr(fall_addr), .target_addr(target_addr), .next_addr(next_addr)
    );

    function automatic logic exp_cond(input logic [3:0] c, input logic z, input logic cy,
                                      input logic s, input logic o, input logic p);
        case (c)
            4'h0: return o;          4'h1: return !o;
            4'h2: return cy;         4'h3: return !cy;
            4'h4: return z;          4'h5: return !z;
            4'h6: return cy || z;    4'h7: return !(cy || z);
            4'h8: return s;          4'h9: return !s;
            4'hA: return p;          4'hB: return !p;
            4'hC: return s != o;     4'hD: return s == o;
            4'hE: return z || (s != o);
            default: return !z && (s == o);
        endcase
    endfunction

    function automatic logic [AW-1:0] exp_target(input logic [AW-1:0] a, input logic [7:0] d);
        longint signed v;
        v = longint'(a) + 2 + longint'($signed(d));
        return v[AW-1:0];
    endfunction

    task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] op, input logic [7:0] d, input logic [AW-1:0] a,
                         input logic [4:0] f);
        logic jx, tx;
        logic [AW-1:0] fx, gx;
        @(negedge clk);
        in_valid = 1'b1; op_byte = op; disp_byte = d; insn_addr = a;
        {zf, cf, sf, ovf, pf} = f;
        @(negedge clk);
        in_valid = 1'b0;
        jx = (op[7:4] == 4'b0111);
        tx = jx && exp_cond(op[3:0], f[4], f[3], f[2], f[1], f[0]);
        fx = a + 32'd2;
        gx = exp_target(a, d);
        chk("R1 out_valid", AW'(out_valid), AW'(1));
        chk(jx ? "R1 is_jcc" : "R2 is_jcc", AW'(is_jcc), AW'(jx));
        chk(jx ? (op[0] ? "R4 taken" : "R3 taken") : "R2 taken", AW'(taken), AW'(tx));
        chk("R5 fall_addr", fall_addr, fx);
        chk("R6 target_addr", target_addr, gx);
        chk("R8 next_addr", next_addr, tx ? gx : fx);
    endtask

    initial begin
        #200000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; in_valid = 1'b0; op_byte = '0; disp_byte = '0; insn_addr = '0;
        {zf, cf, sf, ovf, pf} = '0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 out_valid", AW'(out_valid), 0);
        chk("R9 is_jcc", AW'(is_jcc), 0);
        chk("R9 taken", AW'(taken), 0);
        chk("R9 fall_addr", fall_addr, 0);
        chk("R9 target_addr", target_addr, 0);
        chk("R9 next_addr", next_addr, 0);
        rst = 1'b0;

        // R3/R4: every condition nibble against every flag combination
        for (int c = 0; c < 16; c++)
            for (int f = 0; f < 32; f++)
                apply({4'b0111, 4'(c)}, 8'h10, 32'h0040_1000, 5'(f));

        // R4: zero-flag pair, R7: back five bytes
        apply(8'h74, 8'hFB, 32'h0040_100E, 5'b10000);
        chk("R7 target five back", target_addr, fall_addr - 32'd5);
        apply(8'h75, 8'hFB, 32'h0040_100E, 5'b10000);
        chk("R4 ne with zf set", AW'(taken), 0);

        // R6 wrap at both ends
        apply(8'h70, 8'h7F, 32'hFFFF_FFF0, 5'b00010);
        apply(8'h71, 8'h80, 32'h0000_0004, 5'b00000);
        apply(8'h72, 8'h00, 32'hFFFF_FFFE, 5'b01000);

        // R2: non-jump opcodes with all flags set
        apply(8'h60, 8'hFB, 32'h1000, 5'b11111);
        apply(8'hF4, 8'h05, 32'h2000, 5'b11111);
        apply(8'hEB, 8'h05, 32'h3000, 5'b11111);

        // R10: idle cycle after a taken jump
        apply(8'h74, 8'h20, 32'h5000, 5'b10000);
        @(negedge clk);
        chk("R10 out_valid", AW'(out_valid), 0);
        chk("R10 is_jcc", AW'(is_jcc), 0);
        chk("R10 taken", AW'(taken), 0);

        // random mix
        for (int i = 0; i < 400; i++) begin
            logic [7:0] op;
            op = 8'($urandom);
            if ($urandom % 3 != 0) op[7:4] = 4'b0111;
            apply(op, 8'($urandom), $urandom, 5'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule